// File: doc/BRIEF.md
# Parallel ROM Read-Cycle Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel ROM of 64 Ki locations. The ROM has an active-low chip select and a separate active-low output gate. A client raises a request with a 16-bit address. The sequencer drives that address and pulls chip select low. It then pulls the output gate low later, so that both access windows run out at the same clock edge. On that edge it captures the byte the ROM returns and raises a one-cycle completion pulse.

After the capture, both strobes go high together. The block then waits out a programmable float window, so that the ROM's data pins are released before any other device can use the bus. All timing limits are parameters counted in clock cycles and rounded up:

- `T_ACC` is the access time measured from chip select low (equal to the access time from the address).
- `T_OE` is the access time from the output gate.
- `T_DF` is the float time.

While no read is in progress, chip select stays high so the ROM rests in its low-power standby state.

The parameters must satisfy `T_ACC > T_OE >= 1` and `T_DF >= 1`.

Top module: `rom_rd_ctrl`

## Requirements
- R1: Under reset, and on the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1, and `done` and `busy` are 0.
- R2: While the block is idle and no request is present, `rom_ce_n` and `rom_oe_n` stay 1.
- R3: When `req` is 1 in an idle cycle, the clock edge that ends that cycle loads `rom_addr` with `req_addr`, drives `rom_ce_n` to 0 and sets `busy` to 1. `rom_addr` then holds that value until `busy` returns to 0.
- R4: `rom_oe_n` goes to 0 exactly `T_ACC - T_OE` cycles after `rom_ce_n` goes to 0.
- R5: `rom_q` is sampled on the edge that comes `T_ACC` cycles after `rom_ce_n` fell, which is also `T_OE` cycles after `rom_oe_n` fell. The sampled byte appears on `rd_data` and `done` is 1 for exactly that one following cycle. `rd_data` then holds its value until the next capture.
- R6: The same edge that captures the data drives `rom_ce_n` and `rom_oe_n` back to 1 together.
- R7: `busy` stays 1 for `T_DF` cycles after the strobes rise, then returns to 0. If `req` is held at 1, successive falling edges of `rom_ce_n` are exactly `T_ACC + T_DF + 1` cycles apart.
- R8: A request made while `busy` is 1 is ignored. It does not change `rom_addr` or the byte being read, and it starts no cycle after `busy` returns to 0 unless `req` is still 1 at that point.
- R9: `rom_oe_n` is never 0 while `rom_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, sampled while idle |
| req_addr | input | 16 | Byte address for the request |
| rd_data | output | 8 | Byte captured from the ROM |
| done | output | 1 | One-cycle pulse marking that `rd_data` is new |
| busy | output | 1 | High from acceptance until the float window ends |
| rom_addr | output | 16 | Address driven to the ROM |
| rom_ce_n | output | 1 | Active-low chip select to the ROM |
| rom_oe_n | output | 1 | Active-low output gate to the ROM |
| rom_q | input | 8 | Data pins of the ROM |

## Verification
Each kind of internal fault shows up at the pins within one read cycle:

- A wait counter that is one count off moves the falling edge of `rom_oe_n`, or the `done` pulse, by a cycle within the same read. The bench's ROM model then returns a corrupted byte, because it answers only once both access windows have been met.
- A sequencer that leaves the float state too early shortens `busy`, and with `req` held it shortens the spacing between chip-select falls.
- A sequencer that accepts a request while busy changes `rom_addr` in the middle of the cycle, one edge after that request.

// File: rtl/rom_rd_pkg.sv
// Shared types for the ROM read sequencer.
// Assumes: nothing beyond SystemVerilog packages.
package rom_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_FLOAT  = 2'd3
    } rd_state_t;
endpackage

// File: rtl/rrc_cycle_timer.sv
// Loadable down-counter that times each phase of a read.
// Assumes: load has priority; the counter stops at zero; zero is
// reported combinationally from the current count.
module rrc_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load a phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // Phase lengths of R4/R5/R7 rely on a steady one-per-cycle decrement.
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rrc_sequencer.sv
// Phase controller for one ROM read: select, gate, sample, float.
// Assumes: T_ACC > T_OE >= 1 and T_DF >= 1 (cycles); a request is
// honoured only while idle.
module rrc_sequencer
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int T_ACC  = 6,
    parameter int T_OE   = 4,
    parameter int T_DF   = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              capture,
    output logic              busy
);
    localparam int LEAD_LEN = T_ACC - T_OE;
    localparam logic [CNT_W-1:0] LEAD_RELOAD  = CNT_W'(LEAD_LEN - 1);
    localparam logic [CNT_W-1:0] GATE_RELOAD  = CNT_W'(T_OE - 1);
    localparam logic [CNT_W-1:0] FLOAT_RELOAD = CNT_W'(T_DF - 1);

    rd_state_t state;

    // Advance the phase and drive the address and both strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            rom_addr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    rom_addr <= req_addr;
                    rom_ce_n <= 1'b0;
                    state    <= ST_LEAD;
                end
                ST_LEAD: if (tmr_zero) begin
                    rom_oe_n <= 1'b0;
                    state    <= ST_SAMPLE;
                end
                ST_SAMPLE: if (tmr_zero) begin
                    rom_ce_n <= 1'b1;
                    rom_oe_n <= 1'b1;
                    state    <= ST_FLOAT;
                end
                default: if (tmr_zero) state <= ST_IDLE;
            endcase
        end
    end

    // Choose the timer reload at each phase boundary.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE:   if (req)      begin tmr_load = 1'b1; tmr_val = LEAD_RELOAD;  end
            ST_LEAD:   if (tmr_zero) begin tmr_load = 1'b1; tmr_val = GATE_RELOAD;  end
            ST_SAMPLE: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = FLOAT_RELOAD; end
            default:   ;
        endcase
    end

    assign capture = (state == ST_SAMPLE) && tmr_zero;
    assign busy    = (state != ST_IDLE);

    assert_gate_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);
    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rom_addr));
    assert_strobes_rise_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |-> $rose(rom_oe_n));
    assert_standby_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rom_ce_n && rom_oe_n));
    assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture && state != ST_FLOAT) |=> busy);
endmodule

// File: rtl/rrc_capture.sv
// Registers the ROM byte on the capture strobe and flags it for one cycle.
// Assumes: capture is a single-cycle strobe issued by the sequencer.
module rrc_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rom_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    // Hold the sampled byte and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= capture;
            if (capture)
                rd_data <= rom_q;
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));
endmodule

// File: rtl/rom_rd_ctrl.sv
// Top of the ROM read sequencer: drives address, select and gate with
// cycle-counted waits, captures one byte per request, then waits out
// the float window.
// Assumes: T_ACC > T_OE >= 1, T_DF >= 1; rom_q is valid once both
// access windows have elapsed.
module rom_rd_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 6,
    parameter int T_OE   = 4,
    parameter int T_DF   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_q
);
    localparam int MAX_T = (T_ACC > T_DF) ? T_ACC : T_DF;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             capture;

    rrc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rrc_sequencer #(
        .ADDR_W (ADDR_W),
        .T_ACC  (T_ACC),
        .T_OE   (T_OE),
        .T_DF   (T_DF),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_addr (req_addr),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .rom_addr (rom_addr),
        .rom_ce_n (rom_ce_n),
        .rom_oe_n (rom_oe_n),
        .capture  (capture),
        .busy     (busy)
    );

    rrc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rom_q   (rom_q),
        .rd_data (rd_data),
        .done    (done)
    );

    assert_done_ends_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (rom_ce_n && rom_oe_n && $past(!rom_oe_n)));
endmodule

// File: tb/rom_rd_ctrl_test.sv
module rom_rd_ctrl_test;
    localparam int T_ACC = 6;
    localparam int T_OE  = 4;
    localparam int T_DF  = 4;
    localparam int LEAD  = T_ACC - T_OE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  rd_data;
    logic        done, busy, rom_ce_n, rom_oe_n;
    logic [15:0] rom_addr;
    logic [7:0]  rom_q;

    int checks = 0;
    int errors = 0;
    int ce_cnt = 0;
    int oe_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rom_rd_ctrl #(.T_ACC(T_ACC), .T_OE(T_OE), .T_DF(T_DF)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .rd_data(rd_data), .done(done), .busy(busy), .rom_addr(rom_addr),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_q(rom_q)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // ROM model: returns valid data only once both access windows elapsed.
    always @(negedge clk) begin
        ce_cnt <= rom_ce_n ? 0 : ce_cnt + 1;
        oe_cnt <= rom_oe_n ? 0 : oe_cnt + 1;
    end
    assign rom_q = (ce_cnt >= T_ACC && oe_cnt >= T_OE) ? pat(rom_addr) : ~pat(rom_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset ce_n", rom_ce_n, 1);
        chk("R1 reset oe_n", rom_oe_n, 1);
        chk("R1 reset done", done, 0);
        chk("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset strobes", {rom_ce_n, rom_oe_n, done, busy}, 4'b1100);
    endtask

    task automatic t_idle;
        int bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!rom_ce_n || !rom_oe_n || busy) bad++;
        end
        chk("R2 idle standby violations", bad, 0);
    endtask

    // Full read with cycle-exact checks; req may stay high via 'hold'.
    task automatic t_read(input logic [15:0] a, input bit poke_busy, input logic [15:0] b);
        int oe_bad = 0, ce_bad = 0, done_bad = 0, busy_bad = 0, addr_bad = 0;
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        chk("R3 ce_n low after accept", rom_ce_n, 0);
        chk("R3 rom_addr loaded", rom_addr, a);
        chk("R3 busy set", busy, 1);
        if (poke_busy) begin req = 1'b1; req_addr = b; end
        for (int j = 1; j < T_ACC; j++) begin
            @(negedge clk);
            if (rom_oe_n !== (j < LEAD)) oe_bad++;
            if (rom_ce_n !== 1'b0) ce_bad++;
            if (done !== 1'b0) done_bad++;
            if (rom_addr !== a) addr_bad++;
        end
        chk("R4 oe_n falls after lead", oe_bad, 0);
        chk("R9/R3 ce_n held low", ce_bad, 0);
        chk("R5 no early done", done_bad, 0);
        chk("R8 addr not disturbed", addr_bad, 0);
        @(negedge clk);
        chk("R5 done pulse", done, 1);
        chk("R5 captured byte", rd_data, pat(a));
        chk("R6 strobes released", {rom_ce_n, rom_oe_n}, 2'b11);
        if (poke_busy) req = 1'b0;
        for (int j = 1; j < T_DF; j++) begin
            @(negedge clk);
            if (busy !== 1'b1) busy_bad++;
            if (done !== 1'b0) done_bad++;
            if (rd_data !== pat(a)) done_bad++;
        end
        chk("R7 busy through float", busy_bad, 0);
        chk("R5 single pulse and held data", done_bad, 0);
        @(negedge clk);
        chk("R7 busy clears after float", busy, 0);
        if (poke_busy) begin
            int started = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!rom_ce_n) started++;
            end
            chk("R8 ignored request starts nothing", started, 0);
            chk("R8 data unchanged", rd_data, pat(a));
        end
    endtask

    task automatic t_held_req;
        int gap = 0;
        int caps = 0;
        @(negedge clk);
        req = 1'b1; req_addr = 16'h1234;
        @(negedge clk);
        while (rom_ce_n) @(negedge clk);
        while (!rom_ce_n) @(negedge clk);
        gap = 0;
        while (rom_ce_n) begin @(negedge clk); gap++; end
        chk("R7 back-to-back spacing", gap + T_ACC, T_ACC + T_DF + 1);
        req_addr = 16'hBEEF;
        for (int i = 0; i < 3 * (T_ACC + T_DF + 1); i++) begin
            @(negedge clk);
            if (done && rd_data == pat(16'hBEEF)) caps++;
        end
        req = 1'b0;
        chk("R5 held request reads new address", caps > 0, 1);
        repeat (T_ACC + T_DF + 2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_read(16'h0000, 1'b0, 16'h0);
        t_read(16'hFFFF, 1'b0, 16'h0);
        t_read(16'h8001, 1'b1, 16'h4242);
        t_held_req();
        t_idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule